// File: doc/BRIEF.md
# Time-Multiplexed Tile Crossbar

This block is the switching stage of one tile in a two-dimensional processor array. It connects five word-wide inputs (the north, south, east and west neighbours and the tile's own processing element) to five outputs in the same directions. There is no arbitration and no header decoding. The connection pattern comes from a schedule that is worked out before the array runs.

The schedule is a small table with one entry per time slot. A slot counter steps through the table and wraps after a fixed number of slots, and one full pass through the table makes up one user cycle. Each entry picks a source for every output. The same entry can also park an incoming word in one of two hold registers. A later slot can then route that stored word onward, which resolves conflicts by delaying traffic inside the router. Every hop through the block passes one register stage. The table is filled through a load port while the block is held in reset.

Top module: `tile_xbar`

## Requirements
- R1: While rst_n is low, at the next clock edge every output data bus is zero, every output valid flag is low, the slot counter returns to 0 and both hold registers clear to zero data with valid low.
- R2: Source codes 0, 1, 2, 3 and 4 select the north, south, east, west and local inputs respectively. The word and its valid flag present in slot t appear on the selected output one clock later.
- R3: Source code 7 marks an output as idle. One clock later that output drives zero data with valid low.
- R4: Each hold register has its own write field. A code of 0 to 4 captures that input's word and valid flag at the slot's clock edge. Codes 5 to 7 leave the register unchanged. Output source codes 5 and 6 read hold register 0 and hold register 1.
- R5: After reset is released, the slot counter advances by one each clock and goes from PERIOD-1 back to 0. The entry that is used at each edge is the one indexed by the current slot.
- R6: Schedule writes through cfg_we are accepted only while rst_n is low. While rst_n is high they are ignored and routing is unaffected.
- R7: A schedule entry is 21 bits wide. The source code for output o sits at bits [3o+2:3o], with the output order north=0, south=1, east=2, west=3, local=4. The write field of hold register h sits at bits [15+3h+2:15+3h].
- R8: When a hold register is read and written in the same slot, the output receives the word it held before that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; schedule load window |
| cfg_we | input | 1 | Schedule entry write strobe |
| cfg_addr | input | AW | Slot index being written |
| cfg_word | input | 21 | Schedule entry contents |
| n_i | input | W | North input word |
| n_vi | input | 1 | North input valid |
| s_i | input | W | South input word |
| s_vi | input | 1 | South input valid |
| e_i | input | W | East input word |
| e_vi | input | 1 | East input valid |
| w_i | input | W | West input word |
| w_vi | input | 1 | West input valid |
| pe_i | input | W | Local element input word |
| pe_vi | input | 1 | Local element input valid |
| n_o | output | W | North output word |
| n_vo | output | 1 | North output valid |
| s_o | output | W | South output word |
| s_vo | output | 1 | South output valid |
| e_o | output | W | East output word |
| e_vo | output | 1 | East output valid |
| w_o | output | W | West output word |
| w_vo | output | 1 | West output valid |
| pe_o | output | W | Local element output word |
| pe_vo | output | 1 | Local element output valid |

## Verification
The hardest case to reach from the ports is a hold register that is written and read in the same slot, with the old contents still visible. The old contents only exist if an earlier slot stored a different word. The schedules are generated from rotating formulas, so every output steps through all eight source codes and both hold registers are written from every input across each pass. Some slots therefore write and read the same register. A second schedule loaded after a mid-run reset gives different slot alignments. A burst of schedule writes during normal operation shows that the routing does not change.

// File: rtl/tile_xbar.sv
module tile_xbar #(
  parameter int W = 16,
  parameter int PERIOD = 8,
  localparam int AW = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int EW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [EW-1:0] cfg_word,
  input  logic [W-1:0]  n_i,
  input  logic          n_vi,
  input  logic [W-1:0]  s_i,
  input  logic          s_vi,
  input  logic [W-1:0]  e_i,
  input  logic          e_vi,
  input  logic [W-1:0]  w_i,
  input  logic          w_vi,
  input  logic [W-1:0]  pe_i,
  input  logic          pe_vi,
  output logic [W-1:0]  n_o,
  output logic          n_vo,
  output logic [W-1:0]  s_o,
  output logic          s_vo,
  output logic [W-1:0]  e_o,
  output logic          e_vo,
  output logic [W-1:0]  w_o,
  output logic          w_vo,
  output logic [W-1:0]  pe_o,
  output logic          pe_vo
);
  localparam int NPORT = 5;
  localparam int NHOLD = 2;
  localparam int HBASE = 3 * NPORT;

  logic [EW-1:0] sched [PERIOD];
  logic [AW-1:0] slot;
  logic [EW-1:0] ent;
  logic [W-1:0]  src_d [8];
  logic          src_v [8];
  logic [W-1:0]  hold_d [NHOLD];
  logic          hold_v [NHOLD];
  logic [W-1:0]  out_d [NPORT];
  logic          out_v [NPORT];
  logic [2:0]    osel [NPORT];
  logic [2:0]    hsel [NHOLD];

  always_ff @(posedge clk)
    if (!rst_n && cfg_we) sched[cfg_addr] <= cfg_word;

  always_ff @(posedge clk)
    if (!rst_n) slot <= '0;
    else if (slot == AW'(PERIOD - 1)) slot <= '0;
    else slot <= slot + 1'b1;

  assign ent = sched[slot];

  assign src_d[0] = n_i;  assign src_v[0] = n_vi;
  assign src_d[1] = s_i;  assign src_v[1] = s_vi;
  assign src_d[2] = e_i;  assign src_v[2] = e_vi;
  assign src_d[3] = w_i;  assign src_v[3] = w_vi;
  assign src_d[4] = pe_i; assign src_v[4] = pe_vi;
  assign src_d[5] = hold_d[0]; assign src_v[5] = hold_v[0];
  assign src_d[6] = hold_d[1]; assign src_v[6] = hold_v[1];
  assign src_d[7] = '0;   assign src_v[7] = 1'b0;

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    assign osel[o] = ent[3*o +: 3];
    always_ff @(posedge clk)
      if (!rst_n) begin
        out_d[o] <= '0;
        out_v[o] <= 1'b0;
      end else begin
        out_d[o] <= src_d[osel[o]];
        out_v[o] <= src_v[osel[o]];
      end

    p_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (osel[o] < 3'd5) |=> (out_d[o] == $past(src_d[osel[o]]) && out_v[o] == $past(src_v[osel[o]])));
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (osel[o] == 3'd7) |=> (out_d[o] == '0 && !out_v[o]));
  end

  for (genvar h = 0; h < NHOLD; h++) begin : g_hold
    assign hsel[h] = ent[HBASE + 3*h +: 3];
    always_ff @(posedge clk)
      if (!rst_n) begin
        hold_d[h] <= '0;
        hold_v[h] <= 1'b0;
      end else if (hsel[h] < 3'd5) begin
        hold_d[h] <= src_d[hsel[h]];
        hold_v[h] <= src_v[hsel[h]];
      end

    p_hold_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hsel[h] < 3'd5) |=> (hold_d[h] == $past(src_d[hsel[h]])));
    p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hsel[h] >= 3'd5) |=> $stable(hold_d[h]));
  end

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == AW'(PERIOD - 1)) |=> (slot == '0));
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != AW'(PERIOD - 1)) |=> (slot == $past(slot) + 1'b1));

  assign n_o  = out_d[0]; assign n_vo  = out_v[0];
  assign s_o  = out_d[1]; assign s_vo  = out_v[1];
  assign e_o  = out_d[2]; assign e_vo  = out_v[2];
  assign w_o  = out_d[3]; assign w_vo  = out_v[3];
  assign pe_o = out_d[4]; assign pe_vo = out_v[4];
endmodule

// File: tb/tile_xbar_test.sv
module tile_xbar_test;
  localparam int CLK = 10;
  localparam int W = 16;
  localparam int P = 8;
  localparam int AW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [20:0] cfg_word = '0;
  logic [W-1:0] din [5];
  logic dv [5];
  logic [W-1:0] dout [5];
  logic vout [5];
  logic [W-1:0] n_o, s_o, e_o, w_o, pe_o;
  logic n_vo, s_vo, e_vo, w_vo, pe_vo;

  int checks = 0, fails = 0;
  logic [20:0] model_s [P];
  logic [W-1:0] mh_d [2];
  logic mh_v [2];
  logic [W-1:0] ex_d [5];
  logic ex_v [5];
  int mslot;
  int cyc = 0;

  always #(CLK/2) clk = ~clk;

  tile_xbar #(.W(W), .PERIOD(P)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_word(cfg_word),
    .n_i(din[0]), .n_vi(dv[0]), .s_i(din[1]), .s_vi(dv[1]), .e_i(din[2]), .e_vi(dv[2]),
    .w_i(din[3]), .w_vi(dv[3]), .pe_i(din[4]), .pe_vi(dv[4]),
    .n_o(n_o), .n_vo(n_vo), .s_o(s_o), .s_vo(s_vo), .e_o(e_o), .e_vo(e_vo),
    .w_o(w_o), .w_vo(w_vo), .pe_o(pe_o), .pe_vo(pe_vo));

  assign dout[0] = n_o;  assign vout[0] = n_vo;
  assign dout[1] = s_o;  assign vout[1] = s_vo;
  assign dout[2] = e_o;  assign vout[2] = e_vo;
  assign dout[3] = w_o;  assign vout[3] = w_vo;
  assign dout[4] = pe_o; assign vout[4] = pe_vo;

  // R7 layout: output o at [3o+2:3o], hold h write field at [15+3h+2:15+3h]
  function automatic logic [20:0] mk_entry(int form, int s);
    logic [20:0] e = '0;
    for (int o = 0; o < 5; o++)
      e[3*o +: 3] = (form == 0) ? 3'((s + o) % 8) : 3'((3*s + 5*o + 1) % 8);
    for (int h = 0; h < 2; h++)
      e[15 + 3*h +: 3] = (form == 0) ? 3'((s + 3*h) % 8) : 3'((5*s + h + 2) % 8);
    return e;
  endfunction

  task automatic check_outs(string tag);
    for (int o = 0; o < 5; o++) begin
      checks++;
      if (dout[o] !== ex_d[o] || vout[o] !== ex_v[o]) begin
        fails++;
        $display("FAIL %s out%0d: got %h/%b expected %h/%b", tag, o, dout[o], vout[o], ex_d[o], ex_v[o]);
      end
    end
  endtask

  // R1: reset clears outputs, holds and slot; schedule loaded meanwhile
  task automatic reset_and_load(int form);
    rst_n = 0;
    for (int s = 0; s < P; s++) begin
      @(negedge clk);
      cfg_we = 1; cfg_addr = AW'(s); cfg_word = mk_entry(form, s);
      model_s[s] = mk_entry(form, s);
    end
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
    for (int o = 0; o < 5; o++) begin ex_d[o] = '0; ex_v[o] = 1'b0; end
    for (int h = 0; h < 2; h++) begin mh_d[h] = '0; mh_v[h] = 1'b0; end
    mslot = 0;
    check_outs("R1");
    rst_n = 1;
  endtask

  // R2 R3 R4 R5 R8: per-cycle prediction from a bench-side slot and hold model
  task automatic run(int ncyc, bit spam);
    for (int k = 0; k < ncyc; k++) begin
      if (k > 0) @(negedge clk);
      if (k > 0) check_outs(spam ? "R6" : "R2/R3/R4/R5/R8");
      cyc++;
      for (int i = 0; i < 5; i++) begin
        din[i] = W'(cyc * 37 + i * 1009 + 5);
        dv[i] = ((cyc + i) % 3) != 0;
      end
      cfg_we = spam;
      cfg_addr = AW'(cyc % P);
      cfg_word = 21'h1FFFFF ^ 21'(cyc);
      begin
        logic [20:0] e = model_s[mslot];
        for (int o = 0; o < 5; o++) begin
          int c = int'(e[3*o +: 3]);
          if (c < 5) begin ex_d[o] = din[c]; ex_v[o] = dv[c]; end
          else if (c < 7) begin ex_d[o] = mh_d[c-5]; ex_v[o] = mh_v[c-5]; end
          else begin ex_d[o] = '0; ex_v[o] = 1'b0; end
        end
        for (int h = 0; h < 2; h++) begin
          int c = int'(e[15 + 3*h +: 3]);
          if (c < 5) begin mh_d[h] = din[c]; mh_v[h] = dv[c]; end
        end
      end
      mslot = (mslot == P - 1) ? 0 : mslot + 1;
    end
    @(negedge clk);
    check_outs(spam ? "R6" : "R2/R3/R4/R5/R8");
    cfg_we = 0;
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin din[i] = '0; dv[i] = 0; end
    reset_and_load(0);
    run(5 * P + 3, 0);
    run(3 * P, 1);
    run(2 * P, 0);
    reset_and_load(1);
    run(6 * P + 5, 0);
    run(2 * P, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule